// File: doc/BRIEF.md
# Rollover-Triggered Watchdog Timer

The block is a watchdog for a processor subsystem. A 7-bit counter counts down without stopping. A prescaler divides the core clock by a fixed ratio (65536 by default) and sets the rate of each decrement. An 8-bit control word combines an enable flag (bit 7) with the counter value (bits 6:0). Software writes this word over a simple write strobe and data bus, and the same word can be read back at all times.

While the watchdog is enabled, the block detects expiry when counter bit 6 falls. This happens when the count steps from 40h to 3Fh, not when it reaches zero. On expiry the block drives an active-low reset request for a fixed number of clock cycles (240 by default).

Software keeps the system alive by writing a value from C0h to FFh before expiry. Every write restarts the prescaler. Once software sets the enable flag, only a system reset clears it. A strap input can also force the watchdog on without any software action.

Top module: `wdt_top`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after release, `rd_data_o` reads 7Fh with bit 7 replaced by `hw_en_i`, and `rst_req_n_o` is high.
- R2: `rd_data_o[7]` is the effective enable and `rd_data_o[6:0]` is the counter. A write loads `wr_data_i[6:0]` into the counter, visible the cycle after the write strobe.
- R3: Without writes, the counter decrements by one every DIV cycles and wraps from 00h to 7Fh. It does this whether or not the watchdog is enabled.
- R4: A write restarts the prescaler. The first decrement after a write appears exactly DIV cycles after the write edge.
- R5: When enabled, a decrement from 40h to 3Fh drives `rst_req_n_o` low from the same clock edge on which the counter reads 3Fh.
- R6: Each reset pulse is low for exactly PULSE cycles. A new trigger during an active pulse neither extends nor restarts it.
- R7: While the effective enable is 0, `rst_req_n_o` never goes low, including across a 40h-to-3Fh step.
- R8: Writing bit 7 as 1 sets the enable flag. A later write with bit 7 as 0 leaves it set, and only `rst_n` clears it.
- R9: A write with bit 6 clear drives `rst_req_n_o` low on the next edge, provided the enable is already set or is being set by that same write.
- R10: When `hw_en_i` is high, the effective enable reads 1 and the watchdog behaves as enabled, with no software write.
- R11: When software rewrites a value from C0h to FFh before expiry, `rst_req_n_o` stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| hw_en_i | input | 1 | Strap that forces the watchdog on |
| wr_en_i | input | 1 | Control word write strobe |
| wr_data_i | input | 8 | Control word write data: bit 7 enable, bits 6:0 counter |
| rd_data_o | output | 8 | Control word readback |
| rst_req_n_o | output | 1 | Active-low reset request pulse |

## Verification
Write results are due one edge after the strobe: the loaded counter, the sticky enable, and the reset request for a write that leaves bit 6 clear. A decrement is due exactly DIV edges after a write or after the previous decrement. The reset request falls on the same edge as the 40h-to-3Fh decrement and rises PULSE edges later. The bench shrinks DIV and PULSE through parameters. It samples at the falling edge, after each rising edge has settled. Directed checks sample at exactly these edge counts. A cycle-stepped reference model derived from the requirements also checks every cycle during the random write traffic.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef struct packed {
    logic       en;
    logic [6:0] cnt;
  } wdt_ctrl_t;

  localparam logic [6:0] CNT_RESET  = 7'h7F;
  localparam logic [6:0] CNT_EXPIRE = 7'h40;
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int unsigned DIV = 65536
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  output logic tick_o
);
  localparam int unsigned W      = (DIV > 2) ? $clog2(DIV) : 1;
  localparam int unsigned LAST_I = DIV - 1;
  localparam logic [W-1:0] LAST  = LAST_I[W-1:0];

  logic [W-1:0] cnt_q, cnt_d;

  assign tick_o = (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i || tick_o) cnt_d = '0;
    else                 cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
  import wdt_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick_i,
  input  logic      strap_i,
  input  logic      wr_i,
  input  wdt_ctrl_t wr_data_i,
  output wdt_ctrl_t ctrl_o,
  output logic      fire_o
);
  logic [6:0] cnt_q, cnt_d;
  logic       en_q, en_d;
  logic       en_eff;

  assign en_eff = en_q | strap_i;

  always_comb begin
    cnt_d  = cnt_q;
    en_d   = en_q;
    fire_o = 1'b0;
    if (wr_i) begin
      cnt_d  = wr_data_i.cnt;
      en_d   = en_q | wr_data_i.en;
      fire_o = (en_eff | wr_data_i.en) & ~wr_data_i.cnt[6];
    end else if (tick_i) begin
      cnt_d  = cnt_q - 7'd1;
      fire_o = en_eff & (cnt_q == CNT_EXPIRE);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= CNT_RESET;
      en_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      en_q  <= en_d;
    end
  end

  assign ctrl_o.en  = en_eff;
  assign ctrl_o.cnt = cnt_q;
endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
  parameter int unsigned PULSE = 240
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire_i,
  output logic req_n_o
);
  localparam int unsigned W   = $clog2(PULSE + 1);
  localparam logic [W-1:0] LEN = PULSE[W-1:0];

  logic [W-1:0] left_q, left_d;

  always_comb begin
    left_d = left_q;
    if (left_q != '0) left_d = left_q - 1'b1;
    else if (fire_i)  left_d = LEN;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) left_q <= '0;
    else        left_q <= left_d;
  end

  assign req_n_o = (left_q == '0);
endmodule

// File: rtl/wdt_top.sv
module wdt_top
  import wdt_pkg::*;
#(
  parameter int unsigned DIV   = 65536,
  parameter int unsigned PULSE = 240
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hw_en_i,
  input  logic       wr_en_i,
  input  logic [7:0] wr_data_i,
  output logic [7:0] rd_data_o,
  output logic       rst_req_n_o
);
  logic      tick;
  logic      fire;
  wdt_ctrl_t ctrl;

  wdt_prescaler #(.DIV(DIV)) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (wr_en_i),
    .tick_o(tick)
  );

  wdt_counter u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_i   (tick),
    .strap_i  (hw_en_i),
    .wr_i     (wr_en_i),
    .wr_data_i(wdt_ctrl_t'(wr_data_i)),
    .ctrl_o   (ctrl),
    .fire_o   (fire)
  );

  wdt_pulse #(.PULSE(PULSE)) u_pls (
    .clk    (clk),
    .rst_n  (rst_n),
    .fire_i (fire),
    .req_n_o(rst_req_n_o)
  );

  assign rd_data_o = ctrl;
endmodule

// File: rtl/wdt_chk.sv
module wdt_chk #(
  parameter int unsigned PULSE = 240
) (
  input logic       clk,
  input logic       rst_n,
  input logic       hw_en_i,
  input logic       wr_en_i,
  input logic [7:0] wr_data_i,
  input logic [7:0] rd_data_o,
  input logic       rst_req_n_o
);
  localparam int unsigned W = $clog2(PULSE + 1) + 1;
  logic [W-1:0] low_run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            low_run_q <= '0;
    else if (!rst_req_n_o) low_run_q <= low_run_q + 1'b1;
    else                   low_run_q <= '0;
  end

  a_r2_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> rd_data_o[6:0] == $past(wr_data_i[6:0]));

  a_r3_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_i |=> (rd_data_o[6:0] == $past(rd_data_o[6:0])) ||
                 (rd_data_o[6:0] == $past(rd_data_o[6:0]) - 7'd1));

  a_r6_pulse_bound: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_req_n_o |-> low_run_q < W'(PULSE));

  a_r6_pulse_full: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req_n_o) |-> low_run_q == W'(PULSE));

  a_r7_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_data_o[7] && !wr_en_i && rst_req_n_o) |=> rst_req_n_o);

  a_r8_enable_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data_o[7] && !hw_en_i) |=> rd_data_o[7]);

  a_r9_bad_write_fires: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && (rd_data_o[7] || wr_data_i[7]) && !wr_data_i[6]) |=> !rst_req_n_o);

  a_r10_strap_enables: assert property (@(posedge clk) disable iff (!rst_n)
    hw_en_i |-> rd_data_o[7]);
endmodule

bind wdt_top wdt_chk #(.PULSE(PULSE)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .hw_en_i    (hw_en_i),
  .wr_en_i    (wr_en_i),
  .wr_data_i  (wr_data_i),
  .rd_data_o  (rd_data_o),
  .rst_req_n_o(rst_req_n_o)
);

// File: tb/wdt_top_tb.sv
module wdt_top_tb;
  localparam int DIV   = 16;
  localparam int PULSE = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hw = 1'b0;
  logic       wr = 1'b0;
  logic [7:0] wd = 8'h00;
  logic [7:0] rd;
  logic       rq;

  always #4 clk = ~clk;

  wdt_top #(.DIV(DIV), .PULSE(PULSE)) u_dut (
    .clk(clk), .rst_n(rst_n), .hw_en_i(hw), .wr_en_i(wr),
    .wr_data_i(wd), .rd_data_o(rd), .rst_req_n_o(rq)
  );

  int errs = 0;
  int checks = 0;

  // reference model stepped on each rising edge
  logic [6:0] m_cnt;
  logic       m_en;
  int         m_pre;
  int         m_pl;
  bit         m_tk, m_fr, m_ee;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 7'h7F; m_en = 1'b0; m_pre = 0; m_pl = 0;
    end else begin
      m_tk = (m_pre == DIV - 1);
      m_ee = m_en | hw;
      if (wr) begin
        m_fr  = (m_ee | wd[7]) & ~wd[6];
        m_cnt = wd[6:0];
        m_en  = m_en | wd[7];
        m_pre = 0;
      end else begin
        m_fr  = m_ee & m_tk & (m_cnt == 7'h40);
        if (m_tk) m_cnt = m_cnt - 7'd1;
        m_pre = m_tk ? 0 : m_pre + 1;
      end
      if (m_pl != 0)  m_pl = m_pl - 1;
      else if (m_fr)  m_pl = PULSE;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // advance n falling edges, comparing against the model at each
  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(rd == {m_en | hw, m_cnt}, "R3 model readback", rd, {m_en | hw, m_cnt});
      chk(rq == (m_pl == 0), "R6 model request", rq, m_pl == 0);
    end
  endtask

  task automatic wr_reg(input logic [7:0] d);
    wr = 1'b1; wd = d;
    cyc(1);
    wr = 1'b0;
  endtask

  task automatic do_reset(input logic strap);
    rst_n = 1'b0; hw = strap;
    repeat (3) @(negedge clk);
    chk(rd == {strap, 7'h7F}, "R1 in reset", rd, {strap, 7'h7F});
    rst_n = 1'b1;
  endtask

  int  lowcnt;
  bit  saw_low;
  logic [7:0] v;

  initial begin
    #(8 * 150000);
    errs++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    do_reset(1'b0);
    cyc(1);
    chk(rd == 8'h7F, "R1 after release", rd, 8'h7F);
    chk(rq == 1'b1, "R1 request idle", rq, 1);

    // R3: free run while disabled
    cyc(DIV - 2);
    chk(rd == 8'h7F, "R3 before first step", rd, 8'h7F);
    cyc(1);
    chk(rd == 8'h7E, "R3 first step", rd, 8'h7E);

    // R7: cross 40h->3Fh while disabled
    saw_low = 1'b0;
    for (int i = 0; i < 70 * DIV; i++) begin
      cyc(1);
      if (!rq) saw_low = 1'b1;
    end
    chk(!saw_low, "R7 no pulse while disabled", saw_low, 0);

    // R2/R4: write loads counter and restarts prescaler
    wr_reg(8'hC5);
    chk(rd == 8'hC5, "R2 loaded value", rd, 8'hC5);
    cyc(DIV - 1);
    chk(rd == 8'hC5, "R4 no early step", rd, 8'hC5);
    cyc(1);
    chk(rd == 8'hC4, "R4 step after full period", rd, 8'hC4);

    // R5/R6: expiry from minimum timeout
    wr_reg(8'hC0);
    cyc(DIV - 1);
    chk(rq == 1'b1, "R5 not yet expired", rq, 1);
    cyc(1);
    chk(rd == 8'hBF, "R5 counter at 3F", rd, 8'hBF);
    chk(rq == 1'b0, "R5 request low", rq, 0);
    lowcnt = 1;
    while (!rq && lowcnt < 4 * PULSE) begin cyc(1); if (!rq) lowcnt++; end
    chk(lowcnt == PULSE, "R6 pulse width", lowcnt, PULSE);

    // R8: enable sticky
    wr_reg(8'h45);
    chk(rd == 8'hC5, "R8 enable kept", rd, 8'hC5);
    chk(rq == 1'b1, "R8 no pulse", rq, 1);

    // R9 and R6 retrigger ignored
    wr_reg(8'h85);
    chk(rq == 1'b0, "R9 write fires", rq, 0);
    cyc(2);
    wr_reg(8'h85);
    lowcnt = 4;
    while (!rq && lowcnt < 4 * PULSE) begin cyc(1); if (!rq) lowcnt++; end
    chk(lowcnt == PULSE, "R6 retrigger ignored", lowcnt, PULSE);

    // R10: strap
    do_reset(1'b1);
    cyc(1);
    chk(rd == 8'hFF, "R10 strap enable", rd, 8'hFF);
    chk(rq == 1'b1, "R1 strap idle", rq, 1);
    wr_reg(8'h7F);
    chk(rd == 8'hFF, "R10 enable forced", rd, 8'hFF);
    wr_reg(8'h3F);
    chk(rq == 1'b0, "R10 strap fires", rq, 0);
    cyc(2 * PULSE);

    // R11: periodic refresh keeps request high
    do_reset(1'b0);
    cyc(1);
    saw_low = 1'b0;
    for (int k = 0; k < 30; k++) begin
      v = 8'hC8 | 8'($urandom_range(0, 55));
      wr_reg(v);
      for (int i = 0; i < 4 * DIV; i++) begin cyc(1); if (!rq) saw_low = 1'b1; end
    end
    chk(!saw_low, "R11 refresh holds off reset", saw_low, 0);

    // random traffic against the model
    for (int i = 0; i < 6000; i++) begin
      if ($urandom_range(0, 39) == 0) begin
        if ($urandom_range(0, 3) != 0) v = 8'hC0 | 8'($urandom_range(0, 63));
        else                           v = 8'($urandom_range(0, 255));
        wr_reg(v);
      end else begin
        cyc(1);
      end
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule